// File: doc/BRIEF.md
# Table-Driven Fibonacci Sequencer

This block is the controller for a small datapath of three 32-bit registers, one adder and a set of source multiplexers. It holds a state register. A lookup table supplies both the next state and the complete control word. The table is addressed by the current state and the three command inputs. A separate datapath applies the control word: the controller changes state on the rising clock edge, and the datapath performs its loads on the falling edge that follows.

After reset the controller waits in an idle state for a start command. It then runs one initialization step and enters an endless three-step loop. The first step of each loop forms the next Fibonacci value in the third register. The other two steps shift the older values down. A halt request is taken only at the last step of a loop iteration. The controller then parks in a halted state until a re-arm command sends it back to idle.

Top module: `fibseq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes IDLE (code 0). Every load enable, register select and operand select is 0.
- R2: In IDLE (0), all control outputs are 0. The controller stays in IDLE until `start_i` is high at a rising edge, and then moves to INIT (1). `halt_i` and `rearm_i` have no effect in IDLE.
- R3: INIT (1) loads r0 with the constant 0 (select 0) and r1 with the constant 1 (select 1), and does not load r2. The state that follows is ADD (2). Register n uses select bits `rsrc_o[2n+1:2n]`, and load enable bit n belongs to rn.
- R4: ADD (2) loads r2 from the adder (select 2). Operand A is `asrc_o[1:0]` = 1 (r0), and operand B is `asrc_o[3:2]` = 2 (r1). The state that follows is MOV0 (3).
- R5: MOV0 (3) loads r0 from its neighbour r1 (select 3) and is followed by MOV1 (4). MOV1 (4) loads r1 from its neighbour r2 (select 3). Register n's neighbour is r((n+1) mod 3). Operand selects are 0 in both states.
- R6: In MOV1, `halt_i` high leads to HALT (5) and `halt_i` low leads back to ADD. In every other state `halt_i` has no effect.
- R7: In HALT (5), all control outputs are 0. `rearm_i` high leads to IDLE, and otherwise the state stays HALT. `start_i` has no effect in INIT, ADD, MOV0, MOV1 or HALT.
- R8: No state loads a register that the same state selects as an adder operand. Operand select codes are 0 = constant 1, 1 = r0, 2 = r1, 3 = r2.
- R9: When a datapath is driven by these controls, r2 after the k-th ADD step since the last INIT holds F(k+1) mod 2^32, where F(0)=0 and F(1)=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command, used in IDLE only |
| halt_i | input | 1 | Halt request, used at the end of a loop iteration only |
| rearm_i | input | 1 | Return from HALT to IDLE |
| load_o | output | 3 | Load enable per register, bit n for rn |
| rsrc_o | output | 6 | Register input select, 2 bits per register |
| asrc_o | output | 4 | Adder operand selects, A in [1:0], B in [3:2] |
| state_o | output | 3 | Current state code |

## Verification
The hardest case to reach is a halt request that arrives in a state where it must be ignored. The bench watches its own model state and raises `halt_i` during ADD, MOV0 and INIT, then confirms that the loop continues. It raises a final halt only during MOV1. The sequence is run for more than 47 additions so that the values wrap past 2^32. After a re-arm, a second start checks that initialization clears the old register contents and that the sequence begins again from 0 and 1.

// File: rtl/fibseq_pkg.sv
package fibseq_pkg;

    localparam int NREG   = 3;
    localparam int SEL_W  = 2;
    localparam int NOPER  = 2;
    localparam int ST_W   = 3;
    localparam int NCMD   = 3;
    localparam int ADDR_W = ST_W + NCMD;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_ADD  = 3'd2,
        ST_MOV0 = 3'd3,
        ST_MOV1 = 3'd4,
        ST_HALT = 3'd5
    } seq_state_e;

    // register input selects
    localparam logic [SEL_W-1:0] RS_ZERO  = 2'd0;
    localparam logic [SEL_W-1:0] RS_ONE   = 2'd1;
    localparam logic [SEL_W-1:0] RS_ADDER = 2'd2;
    localparam logic [SEL_W-1:0] RS_NEXT  = 2'd3;
    // adder operand selects
    localparam logic [SEL_W-1:0] AS_ONE   = 2'd0;
    localparam logic [SEL_W-1:0] AS_R0    = 2'd1;
    localparam logic [SEL_W-1:0] AS_R1    = 2'd2;
    localparam logic [SEL_W-1:0] AS_R2    = 2'd3;

    typedef struct packed {
        logic [NOPER-1:0][SEL_W-1:0] asrc;
        logic [NREG-1:0][SEL_W-1:0]  rsrc;
        logic [NREG-1:0]             load;
    } ctrl_word_t;

    typedef struct packed {
        seq_state_e nxt;
        ctrl_word_t ctrl;
    } rom_word_t;

    // address layout: {state, start, halt, rearm}
    function automatic logic [ADDR_W-1:0] rom_addr(seq_state_e st, logic go,
                                                   logic stop, logic rearm);
        return {st, go, stop, rearm};
    endfunction

    // computes one table entry
    function automatic rom_word_t fib_ucode(logic [ADDR_W-1:0] addr);
        rom_word_t  w;
        logic       go, stop, rearm;
        logic [ST_W-1:0] cur;
        {cur, go, stop, rearm} = addr;
        w     = '0;
        w.nxt = ST_IDLE;
        case (cur)
            ST_IDLE: w.nxt = go ? ST_INIT : ST_IDLE;
            ST_INIT: begin
                w.ctrl.load[0] = 1'b1;
                w.ctrl.rsrc[0] = RS_ZERO;
                w.ctrl.load[1] = 1'b1;
                w.ctrl.rsrc[1] = RS_ONE;
                w.nxt          = ST_ADD;
            end
            ST_ADD: begin
                w.ctrl.load[2] = 1'b1;
                w.ctrl.rsrc[2] = RS_ADDER;
                w.ctrl.asrc[0] = AS_R0;
                w.ctrl.asrc[1] = AS_R1;
                w.nxt          = ST_MOV0;
            end
            ST_MOV0: begin
                w.ctrl.load[0] = 1'b1;
                w.ctrl.rsrc[0] = RS_NEXT;
                w.nxt          = ST_MOV1;
            end
            ST_MOV1: begin
                w.ctrl.load[1] = 1'b1;
                w.ctrl.rsrc[1] = RS_NEXT;
                w.nxt          = stop ? ST_HALT : ST_ADD;
            end
            ST_HALT: w.nxt = rearm ? ST_IDLE : ST_HALT;
            default: w.nxt = ST_IDLE;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fibseq_rom.sv
module fibseq_rom
    import fibseq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output rom_word_t         word_o
);
    rom_word_t table_w [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign table_w[a] = fib_ucode(ADDR_W'(a));
    end

    assign word_o = table_w[addr_i];
endmodule

// File: rtl/fibseq_state.sv
module fibseq_state
    import fibseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e nxt_i,
    output seq_state_e state_o
);
    always_ff @(posedge clk) begin
        if (rst) state_o <= ST_IDLE;
        else     state_o <= nxt_i;
    end
endmodule

// File: rtl/fibseq_ctrl.sv
module fibseq_ctrl
    import fibseq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    halt_i,
    input  logic                    rearm_i,
    output logic [NREG-1:0]         load_o,
    output logic [NREG*SEL_W-1:0]   rsrc_o,
    output logic [NOPER*SEL_W-1:0]  asrc_o,
    output logic [ST_W-1:0]         state_o
);
    seq_state_e  cur_q;
    rom_word_t   word;
    logic [ADDR_W-1:0] addr;

    assign addr = rom_addr(cur_q, start_i, halt_i, rearm_i);

    fibseq_rom u_rom (
        .addr_i (addr),
        .word_o (word)
    );

    fibseq_state u_state (
        .clk     (clk),
        .rst     (rst),
        .nxt_i   (word.nxt),
        .state_o (cur_q)
    );

    assign load_o  = word.ctrl.load;
    assign rsrc_o  = word.ctrl.rsrc;
    assign asrc_o  = word.ctrl.asrc;
    assign state_o = cur_q;
endmodule

// File: rtl/fibseq_checker.sv
module fibseq_checker
    import fibseq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic                   halt_i,
    input logic                   rearm_i,
    input logic [NREG-1:0]        load_o,
    input logic [NREG*SEL_W-1:0]  rsrc_o,
    input logic [NOPER*SEL_W-1:0] asrc_o,
    input logic [ST_W-1:0]        state_o
);
    function automatic logic [NREG-1:0] opnd_mask(logic [SEL_W-1:0] s);
        return (s == AS_ONE) ? '0 : NREG'(1 << (s - 1));
    endfunction

    logic [NREG-1:0] rd_mask;
    assign rd_mask = opnd_mask(asrc_o[SEL_W-1:0]) | opnd_mask(asrc_o[2*SEL_W-1:SEL_W]);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> state_o == ST_IDLE); // R1

    AST_QUIET_PARKED: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE || state_o == ST_HALT) |-> (load_o == '0 && rsrc_o == '0 && asrc_o == '0)); // R2

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && start_i) |=> state_o == ST_INIT); // R2

    AST_INIT_TO_ADD: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_INIT |=> state_o == ST_ADD); // R3

    AST_LOOP_BACK: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_MOV1 && !halt_i) |=> state_o == ST_ADD); // R6

    AST_HALT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_MOV1 && halt_i) |=> state_o == ST_HALT); // R6

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HALT && !rearm_i) |=> state_o == ST_HALT); // R7

    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HALT && rearm_i) |=> state_o == ST_IDLE); // R7

    AST_NO_SRC_DEST: assert property (@(posedge clk) disable iff (rst)
        (load_o & rd_mask) == '0); // R8

    AST_ONE_HOT_STEP: assert property (@(posedge clk) disable iff (rst)
        state_o != ST_INIT |-> $onehot0(load_o)); // R5
endmodule

bind fibseq_ctrl fibseq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .halt_i  (halt_i),
    .rearm_i (rearm_i),
    .load_o  (load_o),
    .rsrc_o  (rsrc_o),
    .asrc_o  (asrc_o),
    .state_o (state_o)
);

// File: tb/fibseq_ctrl_bench.sv
module fibseq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, halt = 1'b0, rearm = 1'b0;
    logic [2:0] load;
    logic [5:0] rsrc;
    logic [3:0] asrc;
    logic [2:0] state;

    always #(CLK_PERIOD/2) clk = ~clk;

    fibseq_ctrl u_fibseq_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .halt_i(halt), .rearm_i(rearm),
        .load_o(load), .rsrc_o(rsrc), .asrc_o(asrc), .state_o(state)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    bit run  = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference state model
    int m_state = 0;
    always @(posedge clk) begin
        if (rst) m_state <= 0;
        else case (m_state)
            0: if (start) m_state <= 1;
            1: m_state <= 2;
            2: m_state <= 3;
            3: m_state <= 4;
            4: m_state <= halt ? 5 : 2;
            5: if (rearm) m_state <= 0;
            default: m_state <= 0;
        endcase
    end

    // datapath model and expected Fibonacci values
    logic [31:0] dr [3];
    logic [31:0] ea = 0, eb = 0, ex = 0;

    function automatic logic [31:0] opnd(input logic [1:0] s);
        case (s)
            2'd0: return 32'd1;
            2'd1: return dr[0];
            2'd2: return dr[1];
            default: return dr[2];
        endcase
    endfunction

    always @(negedge clk) begin
        if (run) begin
            logic [2:0] xl; logic [5:0] xr; logic [3:0] xa; string tag;
            logic [31:0] nv [3]; logic [31:0] sum; logic [2:0] rm;
            case (m_state)
                1: begin xl = 3'b011; xr = 6'b00_01_00; xa = 4'b0000; tag = "R3"; end
                2: begin xl = 3'b100; xr = 6'b10_00_00; xa = 4'b10_01; tag = "R4"; end
                3: begin xl = 3'b001; xr = 6'b00_00_11; xa = 4'b0000; tag = "R5"; end
                4: begin xl = 3'b010; xr = 6'b00_11_00; xa = 4'b0000; tag = "R5"; end
                5: begin xl = 3'b000; xr = 6'b0; xa = 4'b0; tag = "R7"; end
                default: begin xl = 3'b000; xr = 6'b0; xa = 4'b0; tag = "R2"; end
            endcase
            check(state === 3'(m_state), {tag, " state"}, 32'(state), 32'(m_state));
            check(load === xl, {tag, " load"}, 32'(load), 32'(xl));
            check(rsrc === xr, {tag, " rsrc"}, 32'(rsrc), 32'(xr));
            check(asrc === xa, {tag, " asrc"}, 32'(asrc), 32'(xa));
            rm = 3'b000;
            for (int k = 0; k < 2; k++) begin
                logic [1:0] s = asrc[2*k +: 2];
                if (s != 2'd0) rm[s-1] = 1'b1;
            end
            check((rm & load) == 3'b000, "R8 read/write overlap", 32'(rm & load), 32'd0);
            sum = opnd(asrc[1:0]) + opnd(asrc[3:2]);
            for (int n = 0; n < 3; n++) begin
                nv[n] = dr[n];
                if (load[n]) case (rsrc[2*n +: 2])
                    2'd0: nv[n] = 32'd0;
                    2'd1: nv[n] = 32'd1;
                    2'd2: nv[n] = sum;
                    default: nv[n] = dr[(n+1) % 3];
                endcase
            end
            for (int n = 0; n < 3; n++) dr[n] = nv[n];
            if (m_state == 1) begin ea = 0; eb = 1; end
            if (m_state == 2) begin
                ex = ea + eb; ea = eb; eb = ex;
                check(dr[2] === ex, "R9 fibonacci r2", dr[2], ex);
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int n = 0; n < 3; n++) dr[n] = 32'hdead_0000 + 32'(n);
        repeat (3) tick();
        check(state === 3'd0 && load === 3'b0, "R1 reset state", 32'(state), 32'd0);
        rst = 1'b0; run = 1'b1;
        // idle ignores halt and rearm
        for (int i = 0; i < 6; i++) begin halt = i[0]; rearm = ~i[0]; tick(); end
        halt = 0; rearm = 0;
        check(state === 3'd0, "R2 idle holds", 32'(state), 32'd0);
        start = 1; tick(); start = 0;
        // long run with stray start and halt outside MOV1
        for (int i = 0; i < 220; i++) begin
            start = 1'($urandom);
            halt  = (m_state != 4) ? 1'($urandom) : 1'b0;
            tick();
        end
        start = 0; halt = 0;
        while (m_state != 2) tick();
        halt = 1; tick(); halt = 0;
        check(state === 3'd3, "R6 halt ignored in ADD", 32'(state), 32'd3);
        while (m_state != 4) tick();
        halt = 1; tick(); halt = 0;
        check(state === 3'd5, "R6 halt taken in MOV1", 32'(state), 32'd5);
        start = 1; repeat (5) tick(); start = 0;
        check(state === 3'd5 && load === 3'b0, "R7 start ignored in HALT", 32'(state), 32'd5);
        rearm = 1; tick(); rearm = 0;
        check(state === 3'd0, "R7 rearm to idle", 32'(state), 32'd0);
        tick();
        start = 1; tick(); start = 0;
        check(state === 3'd1, "R2 restart", 32'(state), 32'd1);
        repeat (40) tick();
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule